// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit converts a segment-relative access into a physical address. Each request names an access kind (instruction fetch, data, or stack), may carry a segment override, and supplies a 16-bit offset and a read/write flag. The unit picks one of four segment registers for the request, then forms the address according to the current mode.

In real mode the selected 16-bit segment value is multiplied by sixteen and added to the offset. The sum wraps within a 20-bit (1 MB) space and the result never faults. In protected mode the segment register instead carries a selector whose low bits index an eight-entry descriptor table. Each entry holds a 24-bit base, a 16-bit limit, a present flag and a writable flag. The offset is checked against the descriptor, and the unit returns either base plus offset or a fault with a code that names its cause.

A single write port loads either a segment register or a descriptor entry. Results are registered and appear one clock after the request.

Top module: `seg_xlate_unit`

## Requirements
- R1: With `prot_en` low, a request yields `rsp_addr` = (segment × 16 + offset) mod 2^20, with bits 23:20 zero and no fault. A000h:5677h and A111h:4567h both give A5677h, and FFFFh:FFFFh gives 0FFEFh.
- R2: Without an override, `req_kind` 00 (fetch) uses segment register 0, 10 (stack) uses register 2, and 01 or 11 (data) uses register 1.
- R3: For a data request with `req_ovr_en` high, `req_ovr_sel` picks the register: 0, 1, 2 or 3.
- R4: An override on a fetch or stack request has no effect on the register that is used.
- R5: With `prot_en` high, bits 2:0 of the selected segment register index the descriptor table. If no fault occurs, `rsp_addr` = (base + offset) mod 2^24.
- R6: A protected offset greater than the limit raises `rsp_fault` with code 01 and `rsp_addr` = 0. An offset equal to the limit is accepted.
- R7: A protected write through a present, non-writable descriptor that passes the limit check faults with code 10 and `rsp_addr` = 0. A read through the same descriptor does not fault.
- R8: Any protected access through a non-present descriptor faults with code 11. This code takes priority over the limit and write-protect codes.
- R9: `rsp_valid`, `rsp_addr`, `rsp_fault` and `rsp_fault_code` are registered and reflect a request one clock after it. In a cycle after no request, all four are zero, and the code is 00 whenever there is no fault.
- R10: `wr_en` with `wr_desc` low loads `wr_data[15:0]` into segment register `wr_idx[1:0]`. With `wr_desc` high it loads descriptor `wr_idx` from `wr_data`, laid out as bit 41 present, bit 40 writable, bits 39:16 base, bits 15:0 limit. A request in the same cycle as a write sees the contents from before the write.
- R11: A synchronous active-low reset clears all segment registers and outputs and makes every descriptor non-present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prot_en | input | 1 | 1 = protected mode, 0 = real mode |
| req_valid | input | 1 | Translation request this cycle |
| req_kind | input | 2 | Access kind: 00 fetch, 01/11 data, 10 stack |
| req_ovr_en | input | 1 | Segment override present |
| req_ovr_sel | input | 2 | Override register index |
| req_offset | input | 16 | Offset within the segment |
| req_write | input | 1 | 1 = write access |
| wr_en | input | 1 | Load strobe |
| wr_desc | input | 1 | 1 = descriptor target, 0 = segment register |
| wr_idx | input | 3 | Target index |
| wr_data | input | 42 | Load value |
| rsp_valid | output | 1 | Result valid |
| rsp_addr | output | 24 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Access faulted |
| rsp_fault_code | output | 2 | 00 none, 01 limit, 10 write-protect, 11 not present |

## Verification
A load through the write port and a translation can fall in the same cycle. They collide when the load targets the very segment register or descriptor that the translation reads. The bench provokes this by issuing a data request together with a load of the data segment register, and a protected request together with a reload of its descriptor. A behavioural model judges the result cycle by cycle: it translates with the old contents and applies the load only afterwards, so the reply must show the old mapping and the next request must show the new one.

// File: rtl/seg_xlate_pkg.sv
// Shared widths, encodings and the descriptor layout for the segmented
// address translation unit. Assumes four segment registers.
package seg_xlate_pkg;
    parameter int SEG_W  = 16;
    parameter int OFF_W  = 16;
    parameter int REAL_W = 20;
    parameter int BASE_W = 24;
    parameter int LIM_W  = 16;
    parameter int NSEG   = 4;
    localparam int SEGIDX_W = $clog2(NSEG);
    localparam int SHIFT_W  = REAL_W - SEG_W;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_DATA  = 2'd1,
        KIND_STACK = 2'd2,
        KIND_DATA2 = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_idx_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_LIMIT  = 2'd1,
        FLT_WPROT  = 2'd2,
        FLT_ABSENT = 2'd3
    } fault_e;

    typedef struct packed {
        logic              present;
        logic              writable;
        logic [BASE_W-1:0] base;
        logic [LIM_W-1:0]  limit;
    } desc_t;

    localparam int DESC_W = $bits(desc_t);
endpackage

// File: rtl/seg_bank.sv
// Segment register bank: NSEG registers of SEG_W bits, loaded one per
// cycle through the write strobe. Assumes the caller decodes the target.
module seg_bank
    import seg_xlate_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ld_en,
    input  logic [SEGIDX_W-1:0]            ld_idx,
    input  logic [SEG_W-1:0]               ld_val,
    output logic [NSEG-1:0][SEG_W-1:0]     seg_q
);
    // Load the addressed register; reset clears all of them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q <= '0;
        end else if (ld_en) begin
            seg_q[ld_idx] <= ld_val;
        end
    end

    // R10
    seg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> seg_q[$past(ld_idx)] == $past(ld_val));
endmodule

// File: rtl/desc_store.sv
// Descriptor table: DESC_N entries of desc_t with one write port and one
// combinational read port. Assumes DESC_N is a power of two.
module desc_store
    import seg_xlate_pkg::*;
#(
    parameter int DESC_N = 8,
    localparam int IDX_W = $clog2(DESC_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  desc_t            ld_val,
    input  logic [IDX_W-1:0] rd_idx,
    output desc_t            rd_val
);
    desc_t ents [DESC_N];

    for (genvar k = 0; k < DESC_N; k++) begin : g_ent
        // Each entry loads when addressed; reset marks it absent.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ents[k] <= '0;
            end else if (ld_en && ld_idx == IDX_W'(k)) begin
                ents[k] <= ld_val;
            end
        end
    end

    // Select the entry named by the selector.
    assign rd_val = ents[rd_idx];

    // R10
    desc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> ents[$past(ld_idx)] == $past(ld_val));

    // R11
    desc_reset_chk: assert property (@(posedge clk)
        !rst_n |=> !ents[0].present && !ents[DESC_N-1].present);
endmodule

// File: rtl/seg_pick.sv
// Chooses the segment register for a request: a default per access kind,
// replaced by the override only for data accesses.
module seg_pick
    import seg_xlate_pkg::*;
(
    input  acc_kind_e              kind,
    input  logic                   ovr_en,
    input  logic [SEGIDX_W-1:0]    ovr_sel,
    output logic [SEGIDX_W-1:0]    sel
);
    // Default by kind, data may be overridden.
    always_comb begin
        unique case (kind)
            KIND_FETCH: sel = SEG_CODE;
            KIND_STACK: sel = SEG_STACK;
            default:    sel = ovr_en ? ovr_sel : SEG_DATA;
        endcase
    end
endmodule

// File: rtl/addr_former.sv
// Combinational address formation and checks. Real mode: shifted segment
// plus offset, wrapped to REAL_W bits. Protected mode: presence, limit and
// write checks in that priority, then base plus offset.
module addr_former
    import seg_xlate_pkg::*;
(
    input  logic              prot,
    input  logic [SEG_W-1:0]  seg_val,
    input  logic [OFF_W-1:0]  offset,
    input  logic              is_write,
    input  desc_t             desc,
    output logic [BASE_W-1:0] addr,
    output fault_e            code
);
    logic [REAL_W-1:0] real_sum;
    logic [BASE_W-1:0] prot_sum;

    // Both sums wrap at their own width.
    always_comb begin
        real_sum = {seg_val, {SHIFT_W{1'b0}}} + REAL_W'(offset);
        prot_sum = desc.base + BASE_W'(offset);
    end

    // Mode select and fault priority: absent, then limit, then write.
    always_comb begin
        addr = '0;
        code = FLT_NONE;
        if (!prot) begin
            addr = BASE_W'(real_sum);
        end else if (!desc.present) begin
            code = FLT_ABSENT;
        end else if (LIM_W'(offset) > desc.limit) begin
            code = FLT_LIMIT;
        end else if (is_write && !desc.writable) begin
            code = FLT_WPROT;
        end else begin
            addr = prot_sum;
        end
    end
endmodule

// File: rtl/seg_xlate_unit.sv
// Segmented address translation unit top. Picks a segment register,
// reads the descriptor its selector names, forms the address and
// registers the result one clock after the request. Loads through the
// write port land at the clock edge, after the same-cycle translation.
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter int DESC_N = 8,
    localparam int IDX_W = $clog2(DESC_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_en,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_ovr_en,
    input  logic [1:0]        req_ovr_sel,
    input  logic [15:0]       req_offset,
    input  logic              req_write,
    input  logic              wr_en,
    input  logic              wr_desc,
    input  logic [2:0]        wr_idx,
    input  logic [41:0]       wr_data,
    output logic              rsp_valid,
    output logic [23:0]       rsp_addr,
    output logic              rsp_fault,
    output logic [1:0]        rsp_fault_code
);
    logic [NSEG-1:0][SEG_W-1:0] seg_q;
    logic [SEGIDX_W-1:0]        sel;
    logic [SEG_W-1:0]           seg_val;
    desc_t                      cur_desc;
    logic [BASE_W-1:0]          nxt_addr;
    fault_e                     nxt_code;

    seg_bank u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_en  (wr_en && !wr_desc),
        .ld_idx (wr_idx[SEGIDX_W-1:0]),
        .ld_val (wr_data[SEG_W-1:0]),
        .seg_q  (seg_q)
    );

    seg_pick u_pick (
        .kind    (acc_kind_e'(req_kind)),
        .ovr_en  (req_ovr_en),
        .ovr_sel (req_ovr_sel),
        .sel     (sel)
    );

    // Value of the chosen segment register.
    assign seg_val = seg_q[sel];

    desc_store #(.DESC_N(DESC_N)) u_desc (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_en  (wr_en && wr_desc),
        .ld_idx (wr_idx[IDX_W-1:0]),
        .ld_val (desc_t'(wr_data)),
        .rd_idx (seg_val[IDX_W-1:0]),
        .rd_val (cur_desc)
    );

    addr_former u_form (
        .prot     (prot_en),
        .seg_val  (seg_val),
        .offset   (req_offset),
        .is_write (req_write),
        .desc     (cur_desc),
        .addr     (nxt_addr),
        .code     (nxt_code)
    );

    // Register the response; idle cycles return all zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_addr       <= '0;
            rsp_fault      <= 1'b0;
            rsp_fault_code <= FLT_NONE;
        end else begin
            rsp_valid      <= req_valid;
            rsp_addr       <= req_valid ? nxt_addr : '0;
            rsp_fault      <= req_valid && (nxt_code != FLT_NONE);
            rsp_fault_code <= req_valid ? nxt_code : FLT_NONE;
        end
    end

    // R9
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && !rsp_fault && rsp_addr == '0);
    // R6
    fault_noaddr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_addr == '0 && rsp_fault_code != FLT_NONE);
    // R1
    real_nofault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !prot_en |=> !rsp_fault && rsp_addr[23:20] == 4'd0);
    // R8
    absent_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && prot_en && !cur_desc.present |=> rsp_fault_code == FLT_ABSENT);
    // R4
    ovr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_kind == KIND_FETCH || req_kind == KIND_STACK |->
        sel == (req_kind == KIND_FETCH ? SEG_CODE : SEG_STACK));
endmodule

// File: tb/seg_xlate_unit_tb.sv
// Bench: behavioural model updated at each rising edge, compared against
// the design at every falling edge.
module seg_xlate_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prot_en = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic        req_ovr_en = 1'b0;
    logic [1:0]  req_ovr_sel = 2'd0;
    logic [15:0] req_offset = 16'd0;
    logic        req_write = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_desc = 1'b0;
    logic [2:0]  wr_idx = 3'd0;
    logic [41:0] wr_data = 42'd0;
    logic        rsp_valid;
    logic [23:0] rsp_addr;
    logic        rsp_fault;
    logic [1:0]  rsp_fault_code;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit started = 0;
    bit done = 0;
    string cur_tag = "R11";
    string exp_tag = "R11";

    // Model state
    int    m_seg [4];
    bit    m_pres [8];
    bit    m_wrt [8];
    longint m_base [8];
    longint m_lim [8];
    bit    e_valid = 0;
    longint e_addr = 0;
    bit    e_fault = 0;
    int    e_code = 0;

    always #10 clk = ~clk;

    seg_xlate_unit u_dut (
        .clk(clk), .rst_n(rst_n), .prot_en(prot_en), .req_valid(req_valid),
        .req_kind(req_kind), .req_ovr_en(req_ovr_en), .req_ovr_sel(req_ovr_sel),
        .req_offset(req_offset), .req_write(req_write), .wr_en(wr_en),
        .wr_desc(wr_desc), .wr_idx(wr_idx), .wr_data(wr_data),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
        .rsp_fault_code(rsp_fault_code)
    );

    // Model: translate with old contents, then apply the load.
    always @(posedge clk) begin
        int s;
        int ix;
        started = 1;
        exp_tag = cur_tag;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_seg[i] = 0;
            for (int i = 0; i < 8; i++) begin
                m_pres[i] = 0; m_wrt[i] = 0; m_base[i] = 0; m_lim[i] = 0;
            end
            e_valid = 0; e_addr = 0; e_fault = 0; e_code = 0;
        end else begin
            e_valid = req_valid; e_addr = 0; e_fault = 0; e_code = 0;
            if (req_valid) begin
                if (req_kind == 2'd0) s = m_seg[0];
                else if (req_kind == 2'd2) s = m_seg[2];
                else s = req_ovr_en ? m_seg[int'(req_ovr_sel)] : m_seg[1];
                if (!prot_en) begin
                    e_addr = (longint'(s) * 16 + longint'(req_offset)) % 1048576;
                end else begin
                    ix = s % 8;
                    if (!m_pres[ix]) e_code = 3;
                    else if (longint'(req_offset) > m_lim[ix]) e_code = 1;
                    else if (req_write && !m_wrt[ix]) e_code = 2;
                    else e_addr = (m_base[ix] + longint'(req_offset)) % 16777216;
                    e_fault = (e_code != 0);
                end
            end
            if (wr_en) begin
                if (!wr_desc) m_seg[int'(wr_idx[1:0])] = int'(wr_data[15:0]);
                else begin
                    m_pres[wr_idx] = wr_data[41];
                    m_wrt[wr_idx]  = wr_data[40];
                    m_base[wr_idx] = longint'(wr_data[39:16]);
                    m_lim[wr_idx]  = longint'(wr_data[15:0]);
                end
            end
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (rsp_valid !== e_valid || rsp_fault !== e_fault ||
                rsp_addr !== 24'(e_addr) || rsp_fault_code !== 2'(e_code)) begin
                errors++;
                $display("FAIL %s: got v=%0b a=%06h f=%0b c=%0d, expected v=%0b a=%06h f=%0b c=%0d",
                         exp_tag, rsp_valid, rsp_addr, rsp_fault, rsp_fault_code,
                         e_valid, 24'(e_addr), e_fault, e_code);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: got %0d cycles, expected under 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic idle(input string tag);
        @(negedge clk);
        cur_tag = tag;
        req_valid = 0; wr_en = 0;
    endtask

    task automatic load_seg(input int idx, input int val, input string tag);
        @(negedge clk);
        cur_tag = tag;
        req_valid = 0;
        wr_en = 1; wr_desc = 0; wr_idx = 3'(idx); wr_data = 42'(val);
    endtask

    task automatic load_desc(input int idx, input bit p, input bit w,
                             input int base, input int lim, input string tag);
        @(negedge clk);
        cur_tag = tag;
        req_valid = 0;
        wr_en = 1; wr_desc = 1; wr_idx = 3'(idx);
        wr_data = {p, w, 24'(base), 16'(lim)};
    endtask

    task automatic req(input bit prot, input int kind, input bit oe, input int os,
                       input int off, input bit wr, input string tag);
        @(negedge clk);
        cur_tag = tag;
        wr_en = 0;
        prot_en = prot; req_valid = 1; req_kind = 2'(kind);
        req_ovr_en = oe; req_ovr_sel = 2'(os); req_offset = 16'(off); req_write = wr;
    endtask

    initial begin
        // R11 reset state
        repeat (3) @(negedge clk);
        cur_tag = "R11";
        @(negedge clk);
        rst_n = 1;
        idle("R11");
        // R11: descriptors absent after reset -> code 11
        req(1, 1, 0, 0, 16'h0000, 0, "R11");
        // Load segment registers
        load_seg(0, 16'h1000, "R10");
        load_seg(1, 16'hA000, "R10");
        load_seg(2, 16'h2000, "R10");
        load_seg(3, 16'hA111, "R10");
        // R1 real mode
        req(0, 1, 0, 0, 16'h5677, 0, "R1");
        req(0, 1, 1, 3, 16'h4567, 1, "R1");
        // R2 defaults
        req(0, 0, 0, 0, 16'h0010, 0, "R2");
        req(0, 2, 0, 0, 16'h0020, 0, "R2");
        req(0, 3, 0, 0, 16'h0030, 0, "R2");
        // R3 data overrides
        for (int k = 0; k < 4; k++) req(0, 1, 1, k, 16'h0004, 0, "R3");
        // R4 overrides ignored on fetch/stack
        req(0, 0, 1, 3, 16'h0008, 0, "R4");
        req(0, 2, 1, 1, 16'h0008, 0, "R4");
        idle("R9");
        idle("R9");
        // R1 wrap
        load_seg(1, 16'hFFFF, "R10");
        req(0, 1, 0, 0, 16'hFFFF, 0, "R1");
        // R10 collision: load DS while data request reads it
        @(negedge clk);
        cur_tag = "R10";
        prot_en = 0; req_valid = 1; req_kind = 2'd1; req_ovr_en = 0; req_offset = 16'h0001;
        wr_en = 1; wr_desc = 0; wr_idx = 3'd1; wr_data = 42'h0_1234;
        req(0, 1, 0, 0, 16'h0001, 0, "R10");
        // Descriptors
        load_desc(2, 1, 1, 24'h123456, 16'h0FFF, "R10");
        load_desc(5, 1, 0, 24'hFFFF00, 16'hFFFF, "R10");
        load_desc(7, 0, 1, 24'h000100, 16'h0000, "R10");
        load_seg(1, 16'h0002, "R10");
        load_seg(3, 16'h0005, "R10");
        load_seg(2, 16'h000F, "R10");
        // R5 / R6 limit boundary
        req(1, 1, 0, 0, 16'h0FFF, 1, "R5");
        req(1, 1, 0, 0, 16'h1000, 0, "R6");
        req(1, 1, 0, 0, 16'h0000, 0, "R5");
        // R5 wrap, R7 write protect
        req(1, 1, 1, 3, 16'h0200, 0, "R5");
        req(1, 1, 1, 3, 16'hFFFF, 1, "R7");
        req(1, 3, 1, 3, 16'h0001, 0, "R7");
        // R8 absent dominates limit and write
        req(1, 2, 0, 0, 16'h0005, 1, "R8");
        req(1, 2, 0, 0, 16'h0000, 0, "R8");
        // R10 collision on descriptor: reload entry 2 while reading it
        @(negedge clk);
        cur_tag = "R10";
        prot_en = 1; req_valid = 1; req_kind = 2'd1; req_ovr_en = 0;
        req_offset = 16'h0010; req_write = 1;
        wr_en = 1; wr_desc = 1; wr_idx = 3'd2; wr_data = {1'b1, 1'b0, 24'h000200, 16'h0008};
        req(1, 1, 0, 0, 16'h0004, 1, "R10");
        req(1, 1, 0, 0, 16'h0010, 0, "R6");
        idle("R9");
        idle("R9");
        // R11 reset mid-run
        @(negedge clk);
        cur_tag = "R11";
        rst_n = 0;
        idle("R11");
        @(negedge clk);
        rst_n = 1;
        req(0, 1, 0, 0, 16'h0123, 0, "R11");
        idle("R9");
        idle("R9");
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule